// File: doc/BRIEF.md
# Per-Output WDM Contention Resolver

This block sits between the label detectors of a wavelength-multiplexed packet switch input and the gate drivers of its broadcast-and-select optical stage. In each time slot, every wavelength channel may present a packet: a valid flag and a short destination label. The block decodes each label into one output port. For each port on its own, it selects at most one of the channels that address it, and drives a channel-by-port matrix of gate enables. Only the selected gates open. Each channel whose packet wins its port gets an acknowledgement. A channel without one is dropped and must retry in a later slot.

Arbitration is a single combinational pass per port, and all ports work in parallel, so the decision time does not grow with the port count. A slot strobe loads the gate matrix and the acknowledgements into registers, which then hold them for the whole slot. A policy input selects one of two schemes. The first is a fixed ranking, in which the lowest-numbered channel always wins. The second is a per-port round-robin rotation.

Top module: `wdm_contention_resolver`

## Requirements
- R1: Channel c's label is the field `label_i[c*2 +: 2]`, and its value (bit 0 plus twice bit 1) is the zero-based index of the output port it addresses; for example, value 2 (bit 0 clear, bit 1 set) addresses the third port. Gate bit `gate_o[p*4 + c]` enables channel c onto port p.
- R2: A channel whose `valid_i` bit is low at a slot strobe gets no gate and no acknowledgement in that slot, whatever its label.
- R3: In every slot, each output port has at most one gate bit set. A port that at least one valid channel addresses has exactly one gate bit set, and that bit belongs to a requesting channel.
- R4: With `rr_mode_i` low, the lowest-numbered requesting channel wins each port.
- R5: `ack_o[c]` is high for a slot exactly when channel c's gate is set on some port in that slot.
- R6: `gate_o` and `ack_o` change only at a rising clock edge where `slot_i` is high. The new values reflect the inputs at that edge and are visible from that edge on. Changes to `valid_i`, `label_i` or `rr_mode_i` between strobes have no effect.
- R7: With `rr_mode_i` high at a strobe, each port searches upward from its own pointer and wraps from channel 3 to channel 0; the first requester found wins. After a grant, that port's pointer moves to the winner plus one, modulo 4. A port that grants nothing, or a strobe with `rr_mode_i` low, leaves the pointer unchanged.
- R8: While `rst_ni` is low, all gates and acknowledgements are low and every round-robin pointer returns to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_i | input | 1 | Slot strobe; loads a new decision |
| rr_mode_i | input | 1 | Policy: 0 fixed ranking, 1 round-robin |
| valid_i | input | N_CH | Per-channel packet present |
| label_i | input | N_CH*LBL_W | Packed destination labels, channel c at bits c*LBL_W |
| gate_o | output | N_OUT*N_CH | Gate enables, bit p*N_CH+c for channel c onto port p |
| ack_o | output | N_CH | Per-channel grant acknowledgement |

## Verification
Every decision appears one clock edge after the strobe that sampled its inputs. The bench therefore drives the inputs and the strobe on a falling edge and compares `gate_o` and `ack_o` on the next falling edge, after exactly one rising edge. Round-robin pointers move at that same strobe edge, so the bench updates its own pointer model once per strobe, right after it computes the expected grants for that slot. The bench checks hold behaviour by changing every input, with the strobe low, for several cycles, and then comparing the outputs with the last decision.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
  localparam int DEF_N_CH  = 4;
  localparam int DEF_N_OUT = 4;

  typedef enum logic {
    POL_FIXED = 1'b0,
    POL_ROUND = 1'b1
  } pol_e;
endpackage

// File: rtl/wcr_label_dec.sv
module wcr_label_dec #(
  parameter int N_CH  = wcr_pkg::DEF_N_CH,
  parameter int N_OUT = wcr_pkg::DEF_N_OUT,
  localparam int LBL_W = $clog2(N_OUT)
) (
  input  logic [N_CH-1:0]                 valid_i,
  input  logic [N_CH*LBL_W-1:0]           label_i,
  output logic [N_OUT-1:0][N_CH-1:0]      req_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign req_o[o][c] = valid_i[c] && (label_i[c*LBL_W +: LBL_W] == LBL_W'(o));
    end
  end
endmodule

// File: rtl/wcr_port_arb.sv
module wcr_port_arb #(
  parameter int N_CH = wcr_pkg::DEF_N_CH,
  localparam int PW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_i,
  input  wcr_pkg::pol_e   pol_i,
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] gnt_o
);
  logic [PW-1:0] ptr_q, start, win_idx;
  logic          found;

  // single pass from the start point, wrapping
  always_comb begin
    int idx;
    start   = (pol_i == wcr_pkg::POL_ROUND) ? ptr_q : '0;
    gnt_o   = '0;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N_CH; k++) begin
      idx = (int'(start) + k) % N_CH;
      if (!found && req_i[idx]) begin
        found        = 1'b1;
        gnt_o[idx]   = 1'b1;
        win_idx      = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (slot_i && pol_i == wcr_pkg::POL_ROUND && found) begin
      ptr_q <= (win_idx == PW'(N_CH-1)) ? '0 : win_idx + 1'b1;
    end
  end

  p_gnt_in_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_work_conserving_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> $onehot(gnt_o));
  p_fixed_head_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == wcr_pkg::POL_FIXED && req_i[0]) |-> gnt_o[0]);
  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_i && pol_i == wcr_pkg::POL_ROUND) |=> $stable(ptr_q));
endmodule

// File: rtl/wdm_contention_resolver.sv
module wdm_contention_resolver #(
  parameter int N_CH  = wcr_pkg::DEF_N_CH,
  parameter int N_OUT = wcr_pkg::DEF_N_OUT,
  localparam int LBL_W = $clog2(N_OUT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    slot_i,
  input  logic                    rr_mode_i,
  input  logic [N_CH-1:0]         valid_i,
  input  logic [N_CH*LBL_W-1:0]   label_i,
  output logic [N_OUT*N_CH-1:0]   gate_o,
  output logic [N_CH-1:0]         ack_o
);
  logic [N_OUT-1:0][N_CH-1:0] req, gnt, gate_q;
  logic [N_CH-1:0]            ack_d, ack_q, col_any;
  wcr_pkg::pol_e              pol;

  assign pol = rr_mode_i ? wcr_pkg::POL_ROUND : wcr_pkg::POL_FIXED;

  wcr_label_dec #(.N_CH(N_CH), .N_OUT(N_OUT)) u_dec (
    .valid_i (valid_i),
    .label_i (label_i),
    .req_o   (req)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_port
    wcr_port_arb #(.N_CH(N_CH)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .slot_i (slot_i),
      .pol_i  (pol),
      .req_i  (req[o]),
      .gnt_o  (gnt[o])
    );
  end

  always_comb begin
    ack_d = '0;
    for (int o = 0; o < N_OUT; o++) ack_d |= gnt[o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      ack_q  <= '0;
    end else if (slot_i) begin
      gate_q <= gnt;
      ack_q  <= ack_d;
    end
  end

  assign gate_o = gate_q;
  assign ack_o  = ack_q;

  always_comb begin
    col_any = '0;
    for (int o = 0; o < N_OUT; o++) col_any |= gate_o[o*N_CH +: N_CH];
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> ($stable(gate_o) && $stable(ack_o)));

  for (genvar o = 0; o < N_OUT; o++) begin : g_port_chk
    p_one_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gate_o[o*N_CH +: N_CH]));
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch_chk
    p_invalid_no_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_i && !valid_i[c]) |=> !ack_o[c]);
    p_ack_has_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o[c] |-> col_any[c]);
  end
endmodule

// File: tb/wdm_contention_resolver_tb_top.sv
module wdm_contention_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot = 1'b0;
  logic        rr_mode = 1'b0;
  logic [3:0]  valid = '0;
  logic [7:0]  label = '0;
  logic [15:0] gate_o;
  logic [3:0]  ack_o;

  int n_run = 0;
  int n_fail = 0;
  int mptr [4];
  bit done = 0;

  always #10 clk = ~clk;

  wdm_contention_resolver dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .slot_i    (slot),
    .rr_mode_i (rr_mode),
    .valid_i   (valid),
    .label_i   (label),
    .gate_o    (gate_o),
    .ack_o     (ack_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected grants; advances the pointer model when rr is set
  function automatic logic [15:0] model(input logic [3:0] v, input logic [7:0] lab, input logic rr);
    logic [15:0] g = '0;
    for (int o = 0; o < 4; o++) begin
      int st = rr ? mptr[o] : 0;
      for (int k = 0; k < 4; k++) begin
        int c = (st + k) % 4;
        if (v[c] && lab[2*c +: 2] == 2'(o)) begin
          g[o*4 + c] = 1'b1;
          if (rr) mptr[o] = (c + 1) % 4;
          break;
        end
      end
    end
    return g;
  endfunction

  function automatic logic [3:0] acks(input logic [15:0] g);
    return g[3:0] | g[7:4] | g[11:8] | g[15:12];
  endfunction

  task automatic do_slot(input logic [3:0] v, input logic [7:0] lab, input logic rr,
                         input string tg, input string ta);
    logic [15:0] eg;
    eg = model(v, lab, rr);
    @(negedge clk);
    valid = v; label = lab; rr_mode = rr; slot = 1'b1;
    @(negedge clk);
    slot = 1'b0;
    chk(tg, gate_o, eg);
    chk(ta, {12'h0, ack_o}, {12'h0, acks(eg)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int o = 0; o < 4; o++) mptr[o] = 0;
    @(negedge clk);
    chk("R8 gates in reset", gate_o, 16'h0);
    chk("R8 acks in reset", {12'h0, ack_o}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] g_hold;
    logic [3:0]  a_hold;
    do_reset();

    // R1 decode: ch0 label 2 -> third port
    do_slot(4'b0001, 8'b0000_0010, 1'b0, "R1 gate", "R1 ack");
    chk("R1 port3 bit", {15'h0, gate_o[8]}, 16'h1);
    // R2 no valid -> nothing
    do_slot(4'b0000, 8'b1110_0100, 1'b0, "R2 gate", "R2 ack");
    // R3 all to port 0, fixed: only ch0
    do_slot(4'b1111, 8'h00, 1'b0, "R3 gate", "R3 ack");
    chk("R3 single gate", gate_o, 16'h0001);

    // exhaustive fixed sweep
    for (int v = 0; v < 16; v++)
      for (int l = 0; l < 256; l++)
        do_slot(4'(v), 8'(l), 1'b0, "R4 sweep gate", "R5 sweep ack");

    // R6 hold between strobes
    g_hold = gate_o; a_hold = ack_o;
    @(negedge clk);
    valid = 4'b1111; label = 8'h1B; rr_mode = 1'b1;
    repeat (3) @(negedge clk);
    valid = 4'b0101; label = 8'hE4; rr_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 gate hold", gate_o, g_hold);
    chk("R6 ack hold", {12'h0, ack_o}, {12'h0, a_hold});

    // R7 rotation on a shared port after reset
    do_reset();
    for (int s = 0; s < 6; s++) begin
      do_slot(4'b1111, 8'h00, 1'b1, "R7 rotate gate", "R7 rotate ack");
    end
    // R8 reset returns pointers to ch0
    do_reset();
    do_slot(4'b1111, 8'h00, 1'b1, "R8 ptr reset gate", "R8 ptr reset ack");
    chk("R8 ch0 wins after reset", {12'h0, ack_o}, 16'h0001);

    // mixed policy random slots with idle gaps
    for (int s = 0; s < 3000; s++) begin
      logic rr;
      rr = ($urandom % 4) != 0;
      do_slot(4'($urandom), 8'($urandom), rr, "R7 random gate", "R5 random ack");
      if ($urandom % 5 == 0) begin
        valid = 4'($urandom); label = 8'($urandom); rr_mode = ~rr_mode;
        @(negedge clk);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule